// File: doc/BRIEF.md
# Two-Class Deflection Torus Router

This block is one switching node of a unidirectional two-dimensional torus. Packets only travel eastward and southward. Every direction carries two link classes: a hop link that reaches the adjacent node, and an express link that skips ahead a compile-time number of nodes. The node holds no packet storage. Every packet that arrives in a cycle leaves in the next cycle, either on the output it asked for or, when it loses arbitration, on another free output. A local processing element can inject packets and receives packets addressed to this node.

Routing is dimension-ordered. A packet keeps moving east until its column matches, then moves south until its row matches, and then it is delivered. In each dimension the remaining wrap-around distance decides the link class. This lets a packet move up from hop to express, or down from express to hop, at every node. In-flight express traffic wins conflicts over hop traffic, and hop traffic wins over injection. This prevents livelock.

Top module: `dfr_router`

## Requirements
- R1: After reset, all four link outputs are invalid and the local delivery strobe is low.
- R2: A packet whose destination column (bits [XW-1:0] of the packet) differs from the node column is routed east. If the column matches and the destination row (the next YW bits) differs, it is routed south. The payload occupies the remaining top bits.
- R3: The remaining distance in the active dimension is computed modulo the torus size. If it is at least EXP_D, the packet takes the express output of that direction; otherwise it takes the hop output.
- R4: A packet addressed to this node is presented on the delivery port in the same cycle it arrives. The delivery port has a valid strobe and the payload.
- R5: Link outputs are registered. A packet granted an output appears on it exactly one clock after it is presented at an input.
- R6: Arbitration order is west-express, north-express, west-hop, north-hop, then injection. An earlier packet always gets its desired output.
- R7: A packet that loses its desired output is deflected. It tries, in order: the other class in the same direction, the same class in the other direction, then the last output. A packet addressed here that loses the delivery port starts this list from the east hop output.
- R8: No packet is dropped. The number of valid link outputs in a cycle equals the number of packets accepted in the previous cycle minus the one delivered locally, if any.
- R9: Injection is accepted (ready high) only when its desired output, or the delivery port for a self-addressed packet, is left free by in-flight traffic. A refused injection has no effect on any output.
- R10: When several arriving packets are addressed here, only the highest-priority one is delivered. The others are deflected as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| w_exp_vld | input | 1 | West express input valid |
| w_exp_pkt | input | PW | West express input packet |
| n_exp_vld | input | 1 | North express input valid |
| n_exp_pkt | input | PW | North express input packet |
| w_hop_vld | input | 1 | West hop input valid |
| w_hop_pkt | input | PW | West hop input packet |
| n_hop_vld | input | 1 | North hop input valid |
| n_hop_pkt | input | PW | North hop input packet |
| inj_vld | input | 1 | Injection request |
| inj_pkt | input | PW | Injected packet |
| inj_ready | output | 1 | Injection accepted this cycle |
| e_hop_vld | output | 1 | East hop output valid |
| e_hop_pkt | output | PW | East hop output packet |
| s_hop_vld | output | 1 | South hop output valid |
| s_hop_pkt | output | PW | South hop output packet |
| e_exp_vld | output | 1 | East express output valid |
| e_exp_pkt | output | PW | East express output packet |
| s_exp_vld | output | 1 | South express output valid |
| s_exp_pkt | output | PW | South express output packet |
| dlv_vld | output | 1 | Local delivery strobe |
| dlv_payload | output | PAYLOAD_W | Delivered payload |

## Verification
Two functions can fall in the same cycle: deflection of in-flight packets and injection. Local delivery can also coincide with the deflection of a second packet addressed to this node. The bench provokes both by presenting all four link inputs at once so that every output is filled, with an injection pending in the same cycle. It also presents two self-addressed packets together, and a self-addressed injection against a self-addressed arrival. The scoreboard judges each case by the exact output every packet lands on one cycle later, the ready level, and the delivered payload.

// File: rtl/dfr_pkg.sv
package dfr_pkg;
  localparam int NNET = 4;   // in-flight inputs, index = priority
  localparam int NIN  = 5;   // plus injection
  localparam int NOUT = 4;
  localparam int SW   = 3;   // input select width

  // output / destination codes
  localparam logic [2:0] W_ES  = 3'd0;
  localparam logic [2:0] W_SS  = 3'd1;
  localparam logic [2:0] W_EE  = 3'd2;
  localparam logic [2:0] W_SE  = 3'd3;
  localparam logic [2:0] W_LOC = 3'd4;

  // k-th output preference for a desired code
  function automatic logic [1:0] pref(input logic [2:0] want, input int k);
    logic [1:0] base;
    base = (want == W_LOC) ? 2'd0 : want[1:0];
    case (k)
      0:       pref = base;
      1:       pref = base ^ 2'd2;
      2:       pref = base ^ 2'd1;
      default: pref = base ^ 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/dfr_route.sv
module dfr_route #(
  parameter int COLS  = 4,
  parameter int ROWS  = 4,
  parameter int EXP_D = 2,
  parameter int MY_X  = 1,
  parameter int MY_Y  = 1,
  parameter int XW    = 2,
  parameter int YW    = 2
) (
  input  logic [XW-1:0] dx,
  input  logic [YW-1:0] dy,
  output logic [2:0]    want
);
  import dfr_pkg::*;

  int rx, ry;

  always_comb begin
    rx = int'(dx) - MY_X;
    if (rx < 0) rx = rx + COLS;
    ry = int'(dy) - MY_Y;
    if (ry < 0) ry = ry + ROWS;
    if (rx != 0)      want = (rx >= EXP_D) ? W_EE : W_ES;
    else if (ry != 0) want = (ry >= EXP_D) ? W_SE : W_SS;
    else              want = W_LOC;
  end
endmodule

// File: rtl/dfr_alloc.sv
module dfr_alloc (
  input  logic [dfr_pkg::NNET-1:0]                net_vld,
  input  logic [dfr_pkg::NNET-1:0][2:0]           net_want,
  input  logic                                    pe_vld,
  input  logic [2:0]                              pe_want,
  output logic [dfr_pkg::NOUT-1:0]                out_take,
  output logic [dfr_pkg::NOUT-1:0][dfr_pkg::SW-1:0] out_sel,
  output logic                                    dlv_take,
  output logic [dfr_pkg::SW-1:0]                  dlv_sel,
  output logic                                    pe_ready
);
  import dfr_pkg::*;

  logic [NNET-1:0] placed;
  logic [1:0]      oi;

  always_comb begin
    out_take = '0;
    out_sel  = '0;
    dlv_take = 1'b0;
    dlv_sel  = '0;
    placed   = '0;
    oi       = '0;
    for (int i = 0; i < NNET; i++) begin
      if (net_vld[i]) begin
        if (net_want[i] == W_LOC && !dlv_take) begin
          dlv_take  = 1'b1;
          dlv_sel   = SW'(i);
          placed[i] = 1'b1;
        end else begin
          for (int k = 0; k < NOUT; k++) begin
            oi = pref(net_want[i], k);
            if (!placed[i] && !out_take[oi]) begin
              out_take[oi] = 1'b1;
              out_sel[oi]  = SW'(i);
              placed[i]    = 1'b1;
            end
          end
        end
      end
    end
    pe_ready = (pe_want == W_LOC) ? !dlv_take : !out_take[pe_want[1:0]];
    if (pe_vld && pe_ready) begin
      if (pe_want == W_LOC) begin
        dlv_take = 1'b1;
        dlv_sel  = SW'(NNET);
      end else begin
        out_take[pe_want[1:0]] = 1'b1;
        out_sel[pe_want[1:0]]  = SW'(NNET);
      end
    end
  end

  // every in-flight packet finds a place
  always_comb begin
    for (int i = 0; i < NNET; i++) begin
      if (net_vld[i]) begin
        p_no_drop_r8: assert (placed[i]);
      end
    end
  end
endmodule

// File: rtl/dfr_link_reg.sv
module dfr_link_reg #(
  parameter int PW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld_d,
  input  logic [PW-1:0] pkt_d,
  output logic          vld_q,
  output logic [PW-1:0] pkt_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      pkt_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (vld_d) pkt_q <= pkt_d;
    end
  end
endmodule

// File: rtl/dfr_router.sv
module dfr_router #(
  parameter int COLS      = 4,
  parameter int ROWS      = 4,
  parameter int EXP_D     = 2,
  parameter int MY_X      = 1,
  parameter int MY_Y      = 1,
  parameter int PAYLOAD_W = 8,
  localparam int XW = $clog2(COLS),
  localparam int YW = $clog2(ROWS),
  localparam int PW = PAYLOAD_W + XW + YW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 w_exp_vld,
  input  logic [PW-1:0]        w_exp_pkt,
  input  logic                 n_exp_vld,
  input  logic [PW-1:0]        n_exp_pkt,
  input  logic                 w_hop_vld,
  input  logic [PW-1:0]        w_hop_pkt,
  input  logic                 n_hop_vld,
  input  logic [PW-1:0]        n_hop_pkt,
  input  logic                 inj_vld,
  input  logic [PW-1:0]        inj_pkt,
  output logic                 inj_ready,
  output logic                 e_hop_vld,
  output logic [PW-1:0]        e_hop_pkt,
  output logic                 s_hop_vld,
  output logic [PW-1:0]        s_hop_pkt,
  output logic                 e_exp_vld,
  output logic [PW-1:0]        e_exp_pkt,
  output logic                 s_exp_vld,
  output logic [PW-1:0]        s_exp_pkt,
  output logic                 dlv_vld,
  output logic [PAYLOAD_W-1:0] dlv_payload
);
  import dfr_pkg::*;

  logic [NIN-1:0]             in_vld;
  logic [NIN-1:0][PW-1:0]     in_pkt;
  logic [NIN-1:0][2:0]        want;
  logic [NOUT-1:0]            out_take;
  logic [NOUT-1:0][SW-1:0]    out_sel;
  logic [NOUT-1:0][PW-1:0]    out_pkt_d;
  logic [NOUT-1:0]            out_vld_q;
  logic [NOUT-1:0][PW-1:0]    out_pkt_q;
  logic                       dlv_take;
  logic [SW-1:0]              dlv_sel;
  logic [PW-1:0]              dlv_pkt;

  // index order is arbitration priority
  assign in_vld = {inj_vld, n_hop_vld, w_hop_vld, n_exp_vld, w_exp_vld};
  assign in_pkt = {inj_pkt, n_hop_pkt, w_hop_pkt, n_exp_pkt, w_exp_pkt};

  for (genvar i = 0; i < NIN; i++) begin : g_route
    dfr_route #(
      .COLS(COLS), .ROWS(ROWS), .EXP_D(EXP_D),
      .MY_X(MY_X), .MY_Y(MY_Y), .XW(XW), .YW(YW)
    ) u_route (
      .dx   (in_pkt[i][XW-1:0]),
      .dy   (in_pkt[i][XW+YW-1:XW]),
      .want (want[i])
    );
  end

  dfr_alloc u_alloc (
    .net_vld  (in_vld[NNET-1:0]),
    .net_want (want[NNET-1:0]),
    .pe_vld   (inj_vld),
    .pe_want  (want[NNET]),
    .out_take (out_take),
    .out_sel  (out_sel),
    .dlv_take (dlv_take),
    .dlv_sel  (dlv_sel),
    .pe_ready (inj_ready)
  );

  // crossbar: next-state data
  always_comb begin
    out_pkt_d = '0;
    dlv_pkt   = '0;
    for (int o = 0; o < NOUT; o++) begin
      for (int i = 0; i < NIN; i++) begin
        if (out_sel[o] == SW'(i)) out_pkt_d[o] = in_pkt[i];
      end
    end
    for (int i = 0; i < NIN; i++) begin
      if (dlv_sel == SW'(i)) dlv_pkt = in_pkt[i];
    end
  end

  for (genvar o = 0; o < NOUT; o++) begin : g_link
    dfr_link_reg #(.PW(PW)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .vld_d (out_take[o]),
      .pkt_d (out_pkt_d[o]),
      .vld_q (out_vld_q[o]),
      .pkt_q (out_pkt_q[o])
    );
  end

  assign e_hop_vld   = out_vld_q[0];
  assign e_hop_pkt   = out_pkt_q[0];
  assign s_hop_vld   = out_vld_q[1];
  assign s_hop_pkt   = out_pkt_q[1];
  assign e_exp_vld   = out_vld_q[2];
  assign e_exp_pkt   = out_pkt_q[2];
  assign s_exp_vld   = out_vld_q[3];
  assign s_exp_pkt   = out_pkt_q[3];
  assign dlv_vld     = dlv_take;
  assign dlv_payload = dlv_pkt[PW-1:XW+YW];

  // ---------------- assertions ----------------
  int n_acc;
  always_comb n_acc = $countones(in_vld[NNET-1:0]) + ((inj_vld && inj_ready) ? 1 : 0);

  p_conserve_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $countones(out_vld_q) == $past(n_acc) - ($past(dlv_vld) ? 1 : 0));

  p_exp_prio_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (w_exp_vld && want[0] == W_EE) |=> (e_exp_vld && e_exp_pkt == $past(w_exp_pkt)));

  p_inj_refuse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_vld && !inj_ready) |-> (|in_vld[NNET-1:0]));

  always_comb begin
    if (dlv_vld) begin
      p_dlv_match_r4: assert (int'(dlv_pkt[XW-1:0]) == MY_X && int'(dlv_pkt[XW+YW-1:XW]) == MY_Y);
    end
  end
endmodule

// File: tb/tb_dfr_router.sv
module tb_dfr_router;
  localparam int PLW = 8;
  localparam int PW  = PLW + 4;

  logic clk = 1'b0;
  logic rst_n;
  always #2 clk = ~clk;

  // index: 0 w_exp, 1 n_exp, 2 w_hop, 3 n_hop, 4 inj
  logic [4:0]          d_v, s_v;
  logic [4:0][PW-1:0]  d_p, s_p;
  // expected outputs: 0 e_hop, 1 s_hop, 2 e_exp, 3 s_exp
  logic [3:0]          e_v;
  logic [3:0][PW-1:0]  e_p;
  logic                e_dlv, e_rdy;
  logic [PLW-1:0]      e_pl;

  logic inj_ready, dlv_vld;
  logic [PLW-1:0] dlv_payload;
  logic [3:0] o_v;
  logic [3:0][PW-1:0] o_p;

  dfr_router dut (
    .clk(clk), .rst_n(rst_n),
    .w_exp_vld(d_v[0]), .w_exp_pkt(d_p[0]),
    .n_exp_vld(d_v[1]), .n_exp_pkt(d_p[1]),
    .w_hop_vld(d_v[2]), .w_hop_pkt(d_p[2]),
    .n_hop_vld(d_v[3]), .n_hop_pkt(d_p[3]),
    .inj_vld(d_v[4]), .inj_pkt(d_p[4]), .inj_ready(inj_ready),
    .e_hop_vld(o_v[0]), .e_hop_pkt(o_p[0]),
    .s_hop_vld(o_v[1]), .s_hop_pkt(o_p[1]),
    .e_exp_vld(o_v[2]), .e_exp_pkt(o_p[2]),
    .s_exp_vld(o_v[3]), .s_exp_pkt(o_p[3]),
    .dlv_vld(dlv_vld), .dlv_payload(dlv_payload)
  );

  typedef struct {
    string              req;
    logic [3:0]         v;
    logic [3:0][PW-1:0] p;
  } exp_t;
  exp_t q[$];

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  function automatic logic [PW-1:0] mk(int x, int y, int pl);
    return {PLW'(pl), 2'(y), 2'(x)};
  endfunction

  task automatic chk(string req, string what, logic [PW-1:0] act, logic [PW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic clr();
    s_v = '0; s_p = '0; e_v = '0; e_p = '0;
    e_dlv = 1'b0; e_pl = '0; e_rdy = 1'b0;
  endtask

  // driver: applies one cycle, checks same-cycle outputs, queues next-cycle ones
  task automatic step(string req);
    exp_t it;
    @(negedge clk);
    d_v = s_v; d_p = s_p;
    #1;
    chk(req, "dlv_vld", PW'(dlv_vld), PW'(e_dlv));
    if (e_dlv) chk(req, "dlv_payload", PW'(dlv_payload), PW'(e_pl));
    if (s_v[4]) chk(req, "inj_ready", PW'(inj_ready), PW'(e_rdy));
    it.req = req; it.v = e_v; it.p = e_p;
    q.push_back(it);
    clr();
  endtask

  // monitor: one cycle after each step
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t it;
      it = q.pop_front();
      chk(it.req, "link valids", PW'(o_v), PW'(it.v));
      for (int o = 0; o < 4; o++) begin
        if (it.v[o]) chk(it.req, $sformatf("link %0d pkt", o), o_p[o], it.p[o]);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    d_v = '0; d_p = '0;
    clr();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk("R1", "link valids", PW'(o_v), '0);
    chk("R1", "dlv_vld", PW'(dlv_vld), '0);

    // R2 R3 R5: east hop, distance 1
    s_v[2] = 1; s_p[2] = mk(2, 0, 8'h11); e_v[0] = 1; e_p[0] = s_p[2];
    step("R2 R3 R5 east hop");
    // R3 upgrade to express, column first (R2)
    s_v[2] = 1; s_p[2] = mk(3, 2, 8'h12); e_v[2] = 1; e_p[2] = s_p[2];
    step("R2 R3 upgrade");
    // R3 wrap distance 3 -> express
    s_v[3] = 1; s_p[3] = mk(0, 1, 8'h13); e_v[2] = 1; e_p[2] = s_p[3];
    step("R3 wrap east");
    // R3 downgrade: express input, row distance 1
    s_v[0] = 1; s_p[0] = mk(1, 2, 8'h14); e_v[1] = 1; e_p[1] = s_p[0];
    step("R2 R3 downgrade south");
    // R3 row wrap -> south express, plus unrelated east hop
    s_v[1] = 1; s_p[1] = mk(1, 0, 8'h15); e_v[3] = 1; e_p[3] = s_p[1];
    s_v[2] = 1; s_p[2] = mk(2, 3, 8'h16); e_v[0] = 1; e_p[0] = s_p[2];
    step("R3 wrap south");
    // R4 local delivery same cycle
    s_v[2] = 1; s_p[2] = mk(1, 1, 8'hA5); e_dlv = 1; e_pl = 8'hA5;
    step("R4 delivery");
    // R6 R7 express beats hop, loser takes east hop
    s_v[0] = 1; s_p[0] = mk(3, 0, 8'h21); e_v[2] = 1; e_p[2] = s_p[0];
    s_v[2] = 1; s_p[2] = mk(0, 0, 8'h22); e_v[0] = 1; e_p[0] = s_p[2];
    step("R6 R7 express priority");
    // R6 R7 R8 R9 full load with pending injection
    s_v[0] = 1; s_p[0] = mk(3, 1, 8'h31); e_v[2] = 1; e_p[2] = s_p[0];
    s_v[1] = 1; s_p[1] = mk(3, 2, 8'h32); e_v[0] = 1; e_p[0] = s_p[1];
    s_v[2] = 1; s_p[2] = mk(2, 1, 8'h33); e_v[1] = 1; e_p[1] = s_p[2];
    s_v[3] = 1; s_p[3] = mk(2, 2, 8'h34); e_v[3] = 1; e_p[3] = s_p[3];
    s_v[4] = 1; s_p[4] = mk(2, 1, 8'h35); e_rdy = 0;
    step("R6 R7 R8 R9 full deflection");
    // R9 injection into free output
    s_v[4] = 1; s_p[4] = mk(2, 3, 8'h41); e_rdy = 1; e_v[0] = 1; e_p[0] = s_p[4];
    step("R9 inject accepted");
    // R9 refused injection has no effect
    s_v[2] = 1; s_p[2] = mk(2, 0, 8'h51); e_v[0] = 1; e_p[0] = s_p[2];
    s_v[4] = 1; s_p[4] = mk(2, 0, 8'h52); e_rdy = 0;
    step("R9 inject refused");
    // R9 injection alongside unrelated traffic
    s_v[0] = 1; s_p[0] = mk(3, 0, 8'h61); e_v[2] = 1; e_p[2] = s_p[0];
    s_v[4] = 1; s_p[4] = mk(1, 2, 8'h62); e_rdy = 1; e_v[1] = 1; e_p[1] = s_p[4];
    step("R9 inject with traffic");
    // R10 two local arrivals
    s_v[0] = 1; s_p[0] = mk(1, 1, 8'h71); e_dlv = 1; e_pl = 8'h71;
    s_v[3] = 1; s_p[3] = mk(1, 1, 8'h72); e_v[0] = 1; e_p[0] = s_p[3];
    step("R10 R7 local contention");
    // R9 self-addressed injection
    s_v[4] = 1; s_p[4] = mk(1, 1, 8'h81); e_rdy = 1; e_dlv = 1; e_pl = 8'h81;
    step("R9 R4 self inject");
    // R9 self injection refused by local arrival
    s_v[1] = 1; s_p[1] = mk(1, 1, 8'h91); e_dlv = 1; e_pl = 8'h91;
    s_v[4] = 1; s_p[4] = mk(1, 1, 8'h92); e_rdy = 0;
    step("R9 R4 self inject refused");
    // flush
    step("R8 idle");
    step("R8 idle");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule